// File: doc/BRIEF.md
# Odd-Ratio Clock Divider with Balanced Duty Cycle

This block divides a source clock by a fixed odd integer `N` of 3 or more. The output has a 50% duty cycle to the half source period. A cycle counter runs from 0 to N-1 on the source rising edge.

A flop on the rising edge decodes the counter into a waveform that is high for (N-1)/2 source cycles and low for (N+1)/2. A flop on the falling edge copies that waveform, so the copy trails it by half a source period. The output clock is the plain OR of the two registered waveforms. The two edge domains are never joined through a count-driven select, because such a select can glitch.

The ratio is fixed at elaboration and cannot change at run time. The active-low asynchronous reset clears every register and holds the output low.

Top module: `odd_clk_div`

## Requirements
- R1: The cycle counter steps by one on each source rising edge and wraps from N-1 to 0, so every output period spans exactly N source periods (2N half periods).
- R2: The rising-edge waveform goes high on the source rising edge that follows a count of 0, and stays high for (N-1)/2 source cycles. Every output rising edge therefore coincides with a source rising edge.
- R3: The falling-edge waveform is the rising-edge waveform delayed by half a source period. Every output falling edge therefore coincides with a source falling edge.
- R4: Each output high phase lasts exactly N source half periods.
- R5: Each output low phase lasts exactly N source half periods.
- R6: While `rst_ni` is low, the output is 0. Asserting `rst_ni` low forces the output to 0 at once, with no clock edge needed.
- R7: After `rst_ni` goes high, the first output rising edge happens on the first source rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_o | output | 1 | Divided clock, period N source cycles, 50% duty |

## Verification
The hardest case to reach from the ports is an asynchronous reset that lands while the output is high, in the middle of a period. The reset must clear both edge domains at once, and the restart must again begin on a clean source rising edge. The bench waits until the output is high and drops the reset just after a source falling edge. It checks that the output is low within a nanosecond. It then releases the reset off-edge and checks the timing of the first new rising edge, followed by every phase width, counted in half periods. Two instances, one with N=5 and one with N=3, cover both a general ratio and the smallest ratio.

// File: rtl/odd_div_pkg.sv
package odd_div_pkg;
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/odd_div_count.sv
module odd_div_count #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_cnt_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == LAST |=> cnt_q == '0);
endmodule

// File: rtl/odd_div_phase.sv
module odd_div_phase #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic q;

  generate
    if (FALLING) begin : g_neg
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= d_i;
      end
    end else begin : g_pos
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= d_i;
      end
    end
  endgenerate

  assign q_o = q;
endmodule

// File: rtl/odd_clk_div.sv
module odd_clk_div #(
  parameter int N = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  localparam int W    = odd_div_pkg::cnt_width(N);
  localparam int HIGH = (N - 1) / 2;

  logic [W-1:0] cnt;
  logic         hi_win;
  logic         rise_q;
  logic         fall_q;

  odd_div_count #(.N(N), .W(W)) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  assign hi_win = (cnt < W'(HIGH));

  odd_div_phase #(.FALLING(1'b0)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hi_win),
    .q_o   (rise_q)
  );

  // half-cycle-delayed copy taken in the falling-edge domain
  odd_div_phase #(.FALLING(1'b1)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rise_q),
    .q_o   (fall_q)
  );

  // OR of two registered waveforms; no select logic
  assign clk_o = rise_q | fall_q;

  assert_rise_at_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rise_q) |-> $past(cnt) == '0);
  assert_fall_tracks_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q == rise_q);
  assert_low_in_reset_R6: assert property (@(posedge clk_i)
    !rst_ni |-> !clk_o);
endmodule

// File: tb/sim_odd_clk_div.sv
`timescale 1ns/1ps
module sim_odd_clk_div;
  localparam int NI = 2;
  localparam int RATIO [NI] = '{5, 3};

  logic clk_i = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] co;

  int checks = 0;
  int fails  = 0;
  real exp_rise = 0.0;
  int exp_q [NI][$];

  always #5 clk_i = ~clk_i;

  odd_clk_div #(.N(5)) u0 (.clk_i(clk_i), .rst_ni(rst_n), .clk_o(co[0]));
  odd_clk_div #(.N(3)) u1 (.clk_i(clk_i), .rst_ni(rst_n), .clk_o(co[1]));

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.1f expected=%0.1f", req, act, exp);
    end
  endtask

  // driver: expected high/low widths in half periods
  task automatic push_exp(input int idx, input int periods);
    for (int p = 0; p < periods; p++) begin
      exp_q[idx].push_back(RATIO[idx]);
      exp_q[idx].push_back(RATIO[idx]);
    end
  endtask

  // monitors
  for (genvar g = 0; g < NI; g++) begin : g_mon
    real t_last = 0.0;
    bit  started = 1'b0;

    always @(negedge rst_n) started = 1'b0;

    always @(posedge co[g]) begin
      if (rst_n) begin
        check(clk_i === 1'b1, "R2", real'(clk_i), 1.0);
        if (!started) begin
          check($realtime == exp_rise, "R7", $realtime, exp_rise);
        end else if (exp_q[g].size() > 0) begin
          automatic int w = $rtoi(($realtime - t_last) / 5.0 + 0.5);
          automatic int e = exp_q[g].pop_front();
          check(w == e, "R5", real'(w), real'(e));
        end
        t_last  = $realtime;
        started = 1'b1;
      end
    end

    always @(negedge co[g]) begin
      if (rst_n && started) begin
        check(clk_i === 1'b0, "R3", real'(clk_i), 0.0);
        if (exp_q[g].size() > 0) begin
          automatic int w = $rtoi(($realtime - t_last) / 5.0 + 0.5);
          automatic int e = exp_q[g].pop_front();
          check(w == e, "R4", real'(w), real'(e));
        end
        t_last = $realtime;
      end
    end
  end

  bit timed_out = 1'b0;
  initial begin
    #200000;
    timed_out = 1'b1;
  end

  initial begin
    fork
      begin
        // R6: output low while reset held
        #12;
        check(co == '0, "R6", real'(co), 0.0);
        @(negedge clk_i); #2;
        exp_rise = $realtime + 3.0;
        for (int i = 0; i < NI; i++) push_exp(i, 6);
        rst_n = 1'b1;
        // R1: after a fixed span the whole queue has drained (periods of N cycles)
        repeat (6 * 5 + 2) @(posedge clk_i);
        #1;
        check(exp_q[0].size() == 0, "R1", real'(exp_q[0].size()), 0.0);
        check(exp_q[1].size() <= 2, "R1", real'(exp_q[1].size()), 2.0);
        // R6: asynchronous reset while output high
        wait (co[0] == 1'b1);
        @(negedge clk_i); #1;
        rst_n = 1'b0;
        #1;
        check(co == '0, "R6", real'(co), 0.0);
        for (int i = 0; i < NI; i++) exp_q[i].delete();
        repeat (3) @(posedge clk_i);
        #2;
        check(co == '0, "R6", real'(co), 0.0);
        @(negedge clk_i); #2;
        exp_rise = $realtime + 3.0;
        for (int i = 0; i < NI; i++) push_exp(i, 4);
        rst_n = 1'b1;
        repeat (4 * 5 + 3) @(posedge clk_i);
        #1;
        check(exp_q[0].size() == 0, "R1", real'(exp_q[0].size()), 0.0);
      end
      begin
        wait (timed_out);
      end
    join_any
    if (timed_out) check(1'b0, "watchdog", 1.0, 0.0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule